// File: doc/BRIEF.md
# Analog Reference Frequency Scaler

This block turns raw converter codes from an analog speed reference into a frequency command for a drive. The reference may be a 0–10 V voltage or a 0–20 mA current loop. Either way the converter front end is expected to place full scale (10 V or 20 mA) at the top code, so the block works on codes alone. Valid samples are summed over a scan window whose length is a programmable number of 4 ms timebase ticks. At the end of the window the sum is divided by the sample count. The rounded average then goes through range normalization, slope direction, gain and signed bias, and is finally scaled to the configured upper frequency limit.

All settings are sampled at a window boundary. The scan length of the next window and the mapping of the window that just closed therefore always come from one consistent snapshot. A sequential divider forms the average over a few dozen clock cycles, which is a negligible delay against a 4 ms tick. The result appears on a registered output together with a one-clock valid strobe.

Top module: `afreq_scaler`

## Requirements
- R1: In full-range mode (`cfg_live_zero`=0) the input fraction is avg/FS, where FS = 2^ADC_W−1 (4095 by default) stands for 10 V or 20 mA.
- R2: In live-zero mode (`cfg_live_zero`=1) the zero point is Z = FS/5 (819, meaning 2 V or 4 mA) and the fraction is (avg−Z)/(FS−Z). Any average below Z gives a fraction of zero.
- R3: The fraction is multiplied by `cfg_gain` percent, which ranges from 0 to 200.
- R4: `cfg_bias` percent (0–100) is added after gain, or subtracted when `cfg_bias_neg`=1. The combined value is saturated to the range 0–100 %.
- R5: With `cfg_slope_inv`=1 the fraction f is replaced by 1−f before gain and bias are applied, so the minimum input maps to the top of the range.
- R6: `freq_out` = combined fraction × `cfg_fmax` in 0.01 Hz units, rounded half up. The average itself is (sum + count/2)/count, floored, which rounds it half up.
- R7: A window closes on the tick that completes `cfg_scan` ticks of the latched setting. A value of 0 counts as 1 and values above 100 count as 100. No result is produced before the window closes.
- R8: A valid sample that arrives in the same cycle as the closing tick belongs to the closing window. The sum and the count restart from zero after every window.
- R9: Settings are captured at the window boundary. A change made after the boundary neither alters the pending result nor shortens or lengthens the running window.
- R10: A window with no valid samples reuses the last computed average, mapped with the newly captured settings.
- R11: `freq_valid` is a single-cycle pulse, and `freq_out` stays constant between pulses.
- R12: A synchronous reset clears `freq_out` to 0 and `freq_valid` to 0, empties the accumulator and restarts the tick count with a latched scan length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Converter sample present this cycle |
| smp_data | input | ADC_W | Converter code, full scale = 10 V / 20 mA |
| tick_4ms | input | 1 | One-cycle pulse every 4 ms |
| cfg_gain | input | 8 | Gain in percent, 0–200 |
| cfg_bias | input | 7 | Bias magnitude in percent, 0–100 |
| cfg_bias_neg | input | 1 | 1 = subtract bias |
| cfg_slope_inv | input | 1 | 1 = inverted slope |
| cfg_live_zero | input | 1 | 1 = 2–10 V / 4–20 mA range |
| cfg_scan | input | 7 | Window length in 4 ms ticks, 1–100 |
| cfg_fmax | input | 16 | Upper frequency limit, 0.01 Hz units |
| freq_out | output | 16 | Frequency command, 0.01 Hz units |
| freq_valid | output | 1 | One-cycle pulse on each new command |

## Verification
A valid sample can land in the same cycle as the tick that closes the window, so accumulation and window closure fall in the same cycle. The bench provokes this by driving a code of 4095 together with the closing tick after a code of 0. It then expects a command of 3001 (an average of 2048), which only holds if the coinciding sample was counted in the closing window. A second coincidence, a setting change right after a boundary while the division is still running, is judged by checking that the pending result still uses the old frequency limit.

// File: rtl/afs_pkg.sv
package afs_pkg;
    localparam int GAIN_W = 8;
    localparam int BIAS_W = 7;
    localparam int SCAN_W = 7;
    localparam int FREQ_W = 16;
    localparam int SCAN_MAX = 100;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [BIAS_W-1:0] bias;
        logic              bias_neg;
        logic              slope_inv;
        logic              live_zero;
        logic [SCAN_W-1:0] scan;
        logic [FREQ_W-1:0] fmax;
    } afs_cfg_t;

    localparam afs_cfg_t CFG_RESET = '{
        gain: GAIN_W'(100), bias: '0, bias_neg: 1'b0, slope_inv: 1'b0,
        live_zero: 1'b0, scan: SCAN_W'(1), fmax: '0
    };
endpackage

// File: rtl/afs_window.sv
module afs_window
    import afs_pkg::*;
#(
    parameter int ADC_W = 12,
    parameter int CNT_W = 16,
    localparam int SUM_W = ADC_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [ADC_W-1:0] smp_data,
    input  logic             tick,
    input  afs_cfg_t         cfg_in,
    output afs_cfg_t         cfg_lat,
    output logic             win_end,
    output logic             win_empty,
    output logic [SUM_W-1:0] win_sum,
    output logic [CNT_W-1:0] win_cnt
);
    typedef struct packed {
        logic [SCAN_W-1:0] tick_cnt;
        logic [SUM_W-1:0]  acc_sum;
        logic [CNT_W-1:0]  acc_cnt;
        afs_cfg_t          cfg;
        logic              end_p;
        logic              empty;
        logic [SUM_W-1:0]  out_sum;
        logic [CNT_W-1:0]  out_cnt;
    } win_st_t;

    win_st_t st_d, st_q;
    logic              take;
    logic [SUM_W-1:0]  sum_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic [SCAN_W-1:0] scan_eff;
    logic              boundary;

    always_comb begin
        st_d       = st_q;
        st_d.end_p = 1'b0;
        take       = smp_valid && (st_q.acc_cnt != '1);
        sum_nx     = st_q.acc_sum + (take ? SUM_W'(smp_data) : '0);
        cnt_nx     = st_q.acc_cnt + (take ? CNT_W'(1) : '0);
        if (st_q.cfg.scan == '0)
            scan_eff = SCAN_W'(1);
        else if (st_q.cfg.scan > SCAN_W'(SCAN_MAX))
            scan_eff = SCAN_W'(SCAN_MAX);
        else
            scan_eff = st_q.cfg.scan;
        boundary = tick && (({1'b0, st_q.tick_cnt} + 1'b1) >= {1'b0, scan_eff});

        if (tick)
            st_d.tick_cnt = boundary ? '0 : st_q.tick_cnt + 1'b1;

        if (boundary) begin
            st_d.end_p   = 1'b1;
            st_d.empty   = (cnt_nx == '0);
            st_d.out_sum = sum_nx;
            st_d.out_cnt = cnt_nx;
            st_d.acc_sum = '0;
            st_d.acc_cnt = '0;
            st_d.cfg     = cfg_in;
        end else begin
            st_d.acc_sum = sum_nx;
            st_d.acc_cnt = cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.tick_cnt <= '0;
            st_q.acc_sum  <= '0;
            st_q.acc_cnt  <= '0;
            st_q.cfg      <= CFG_RESET;
            st_q.end_p    <= 1'b0;
            st_q.empty    <= 1'b1;
            st_q.out_sum  <= '0;
            st_q.out_cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_lat   = st_q.cfg;
    assign win_end   = st_q.end_p;
    assign win_empty = st_q.empty;
    assign win_sum   = st_q.out_sum;
    assign win_cnt   = st_q.out_cnt;

    // R7: tick counter stays below the largest legal window
    a_r7_tick_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.tick_cnt < SCAN_W'(SCAN_MAX));
    // R9: latched settings move only together with a window close
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !st_q.end_p |-> $stable(st_q.cfg));
    // R8: an empty accumulator holds no sum
    a_r8_empty_sum: assert property (@(posedge clk) disable iff (rst)
        (st_q.acc_cnt == '0) |-> (st_q.acc_sum == '0));
    // R10: the empty flag agrees with the captured count
    a_r10_empty_flag: assert property (@(posedge clk) disable iff (rst)
        st_q.end_p |-> (st_q.empty == (st_q.out_cnt == '0)));
endmodule

// File: rtl/afs_divider.sv
module afs_divider #(
    parameter int NUM_W = 29,
    parameter int DEN_W = 16,
    parameter int Q_W   = 12,
    localparam int STEP_W = $clog2(NUM_W),
    localparam logic [NUM_W-1:0] QMAX = NUM_W'((1 << Q_W) - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        logic [DEN_W-1:0]  rem;
        logic [NUM_W-1:0]  qacc;
        logic [DEN_W-1:0]  dv;
        logic              done;
        logic [Q_W-1:0]    avg;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DEN_W:0]   rem_sh;
    logic [NUM_W-1:0] q_sh;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        rem_sh    = {st_q.rem, st_q.qacc[NUM_W-1]};
        q_sh      = {st_q.qacc[NUM_W-2:0], 1'b0};
        if (rem_sh >= {1'b0, st_q.dv}) begin
            rem_sh  = rem_sh - {1'b0, st_q.dv};
            q_sh[0] = 1'b1;
        end
        if (start) begin
            st_d.busy = 1'b1;
            st_d.step = '0;
            st_d.rem  = '0;
            st_d.qacc = num;
            st_d.dv   = den;
        end else if (st_q.busy) begin
            st_d.rem  = rem_sh[DEN_W-1:0];
            st_d.qacc = q_sh;
            st_d.step = st_q.step + 1'b1;
            if (st_q.step == STEP_W'(NUM_W - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.avg  = (q_sh > QMAX) ? QMAX[Q_W-1:0] : q_sh[Q_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b0;
            st_q.step <= '0;
            st_q.rem  <= '0;
            st_q.qacc <= '0;
            st_q.dv   <= '0;
            st_q.done <= 1'b0;
            st_q.avg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;
    assign quo  = st_q.avg;

    // R7: windows are far apart, a new division never interrupts one in flight
    a_r7_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !st_q.busy);
    // R10: a division is never launched with a zero count
    a_r10_den_nonzero: assert property (@(posedge clk) disable iff (rst)
        start |-> (den != '0));
    // R6: the average changes only when a division completes
    a_r6_avg_hold: assert property (@(posedge clk) disable iff (rst)
        !st_q.done |-> $stable(st_q.avg));
endmodule

// File: rtl/afs_map.sv
module afs_map
    import afs_pkg::*;
#(
    parameter int ADC_W = 12,
    localparam int FS    = (1 << ADC_W) - 1,
    localparam int ZERO  = FS / 5,
    localparam int SPAN  = FS - ZERO,
    localparam int CW    = ADC_W + GAIN_W + 1,
    localparam int WIDE  = CW + FREQ_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [ADC_W-1:0]  avg,
    input  logic [GAIN_W-1:0] gain,
    input  logic [BIAS_W-1:0] bias,
    input  logic              bias_neg,
    input  logic              slope_inv,
    input  logic              live_zero,
    input  logic [FREQ_W-1:0] fmax,
    output logic [FREQ_W-1:0] freq,
    output logic              valid
);
    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic              valid;
    } map_st_t;

    map_st_t st_d, st_q;
    logic [ADC_W-1:0] x_raw, x_dir, den_s;
    logic [CW-1:0]    prod, bterm, comb, top;
    logic [WIDE-1:0]  scaled, quot;

    always_comb begin
        if (live_zero)
            x_raw = (avg < ADC_W'(ZERO)) ? '0 : avg - ADC_W'(ZERO);
        else
            x_raw = avg;
        den_s = live_zero ? ADC_W'(SPAN) : ADC_W'(FS);
        x_dir = slope_inv ? den_s - x_raw : x_raw;

        prod  = CW'(x_dir) * CW'(gain);
        bterm = CW'(bias) * CW'(den_s);
        if (bias_neg)
            comb = (bterm > prod) ? '0 : prod - bterm;
        else
            comb = prod + bterm;
        top  = CW'(den_s) * CW'(100);
        if (comb > top)
            comb = top;

        scaled = WIDE'(comb) * WIDE'(fmax) + WIDE'(den_s) * WIDE'(50);
        quot   = live_zero ? scaled / WIDE'(SPAN * 100) : scaled / WIDE'(FS * 100);

        st_d       = st_q;
        st_d.valid = trig;
        if (trig)
            st_d.freq = FREQ_W'(quot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.freq  <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign freq  = st_q.freq;
    assign valid = st_q.valid;

    // R11: strobe lasts a single cycle
    a_r11_pulse: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |=> !st_q.valid);
    // R11: command holds between strobes
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !st_q.valid |-> $stable(st_q.freq));
    // R4: saturation keeps the command at or below the limit
    a_r4_limit: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |-> (st_q.freq <= fmax));
    // R12: first cycle out of reset shows a cleared output
    a_r12_reset_out: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.freq == '0 && !st_q.valid));
endmodule

// File: rtl/afreq_scaler.sv
module afreq_scaler
    import afs_pkg::*;
#(
    parameter int ADC_W = 12,
    parameter int CNT_W = 16,
    localparam int SUM_W = ADC_W + CNT_W,
    localparam int NUM_W = SUM_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [ADC_W-1:0]  smp_data,
    input  logic              tick_4ms,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic [BIAS_W-1:0] cfg_bias,
    input  logic              cfg_bias_neg,
    input  logic              cfg_slope_inv,
    input  logic              cfg_live_zero,
    input  logic [SCAN_W-1:0] cfg_scan,
    input  logic [FREQ_W-1:0] cfg_fmax,
    output logic [FREQ_W-1:0] freq_out,
    output logic              freq_valid
);
    afs_cfg_t         cfg_in, cfg_lat;
    logic             win_end, win_empty, div_start, div_done, map_trig;
    logic [SUM_W-1:0] win_sum;
    logic [CNT_W-1:0] win_cnt;
    logic [NUM_W-1:0] div_num;
    logic [ADC_W-1:0] avg;

    always_comb begin
        cfg_in.gain      = cfg_gain;
        cfg_in.bias      = cfg_bias;
        cfg_in.bias_neg  = cfg_bias_neg;
        cfg_in.slope_inv = cfg_slope_inv;
        cfg_in.live_zero = cfg_live_zero;
        cfg_in.scan      = cfg_scan;
        cfg_in.fmax      = cfg_fmax;
        div_start = win_end && !win_empty;
        div_num   = NUM_W'(win_sum) + NUM_W'(win_cnt >> 1);
        map_trig  = div_done || (win_end && win_empty);
    end

    afs_window #(.ADC_W(ADC_W), .CNT_W(CNT_W)) u_win (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .tick(tick_4ms), .cfg_in(cfg_in), .cfg_lat(cfg_lat),
        .win_end(win_end), .win_empty(win_empty),
        .win_sum(win_sum), .win_cnt(win_cnt)
    );

    afs_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W), .Q_W(ADC_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .num(div_num),
        .den(win_cnt), .done(div_done), .quo(avg)
    );

    afs_map #(.ADC_W(ADC_W)) u_map (
        .clk(clk), .rst(rst), .trig(map_trig), .avg(avg),
        .gain(cfg_lat.gain), .bias(cfg_lat.bias), .bias_neg(cfg_lat.bias_neg),
        .slope_inv(cfg_lat.slope_inv), .live_zero(cfg_lat.live_zero),
        .fmax(cfg_lat.fmax), .freq(freq_out), .valid(freq_valid)
    );

    // R10: an empty window is never sent to the divider
    a_r10_no_empty_div: assert property (@(posedge clk) disable iff (rst)
        div_start |-> (win_cnt != '0));
endmodule

// File: tb/tb_afreq_scaler.sv
module tb_afreq_scaler;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        tick_4ms = 1'b0;
    logic [7:0]  cfg_gain = 8'd100;
    logic [6:0]  cfg_bias = '0;
    logic        cfg_bias_neg = 1'b0;
    logic        cfg_slope_inv = 1'b0;
    logic        cfg_live_zero = 1'b0;
    logic [6:0]  cfg_scan = 7'd1;
    logic [15:0] cfg_fmax = 16'd6000;
    logic [15:0] freq_out;
    logic        freq_valid;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    afreq_scaler dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .tick_4ms(tick_4ms), .cfg_gain(cfg_gain), .cfg_bias(cfg_bias),
        .cfg_bias_neg(cfg_bias_neg), .cfg_slope_inv(cfg_slope_inv),
        .cfg_live_zero(cfg_live_zero), .cfg_scan(cfg_scan), .cfg_fmax(cfg_fmax),
        .freq_out(freq_out), .freq_valid(freq_valid)
    );

    typedef struct packed {
        logic [11:0] s0;
        logic [11:0] s1;
        logic [7:0]  gain;
        logic [6:0]  bias;
        logic        neg;
        logic        inv;
        logic        live;
        logic [15:0] fmax;
        logic [15:0] expf;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{12'd4095, 12'd4095, 8'd100, 7'd0,   1'b0, 1'b0, 1'b0, 16'd6000,  16'd6000}, // R1
        '{12'd0,    12'd0,    8'd100, 7'd50,  1'b0, 1'b0, 1'b0, 16'd6000,  16'd3000}, // R4
        '{12'd2048, 12'd2047, 8'd100, 7'd50,  1'b1, 1'b0, 1'b0, 16'd6000,  16'd1},    // R4
        '{12'd500,  12'd600,  8'd100, 7'd0,   1'b0, 1'b0, 1'b1, 16'd6000,  16'd0},    // R2
        '{12'd2457, 12'd2457, 8'd100, 7'd0,   1'b0, 1'b0, 1'b1, 16'd6000,  16'd3000}, // R2
        '{12'd0,    12'd0,    8'd100, 7'd0,   1'b0, 1'b1, 1'b0, 16'd6000,  16'd6000}, // R5
        '{12'd4095, 12'd4095, 8'd100, 7'd0,   1'b0, 1'b1, 1'b0, 16'd6000,  16'd0},    // R5
        '{12'd1024, 12'd1024, 8'd200, 7'd0,   1'b0, 1'b0, 1'b0, 16'd6000,  16'd3001}, // R3
        '{12'd4000, 12'd4000, 8'd200, 7'd0,   1'b0, 1'b0, 1'b0, 16'd6000,  16'd6000}, // R3
        '{12'd0,    12'd0,    8'd0,   7'd100, 1'b0, 1'b0, 1'b0, 16'd6000,  16'd6000}, // R4
        '{12'd4095, 12'd4095, 8'd100, 7'd100, 1'b1, 1'b0, 1'b0, 16'd6000,  16'd0},    // R4
        '{12'd1000, 12'd1001, 8'd100, 7'd0,   1'b0, 1'b0, 1'b0, 16'd5000,  16'd1222}, // R6
        '{12'd1,    12'd2,    8'd100, 7'd0,   1'b0, 1'b0, 1'b0, 16'd40950, 16'd20},   // R6
        '{12'd819,  12'd819,  8'd100, 7'd0,   1'b0, 1'b1, 1'b1, 16'd6000,  16'd6000}  // R2 R5
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic drive(input logic v, input logic [11:0] d, input logic t);
        smp_valid = v;
        smp_data  = d;
        tick_4ms  = t;
        @(negedge clk);
        smp_valid = 1'b0;
        tick_4ms  = 1'b0;
    endtask

    task automatic wait_out(input string tag, input int exp_v);
        logic        got = 1'b0;
        logic [15:0] f = '0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (freq_valid) begin
                got = 1'b1;
                f = freq_out;
                break;
            end
        end
        check(got, {tag, " strobe"}, int'(got), 1);
        check(f == 16'(exp_v), tag, int'(f), exp_v);
        if (got) begin
            @(negedge clk);
            check(!freq_valid, "R11 strobe width", int'(freq_valid), 0);
            check(freq_out == f, "R11 hold", int'(freq_out), int'(f));
        end
    endtask

    task automatic expect_quiet(input string tag, input int cycles);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (freq_valid) seen = 1'b1;
        end
        check(!seen, tag, int'(seen), 0);
    endtask

    task automatic set_plain(input logic [15:0] fm);
        cfg_gain = 8'd100; cfg_bias = '0; cfg_bias_neg = 1'b0;
        cfg_slope_inv = 1'b0; cfg_live_zero = 1'b0; cfg_fmax = fm;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(freq_out == 16'd0, "R12 reset freq", int'(freq_out), 0);
        check(!freq_valid, "R12 reset strobe", int'(freq_valid), 0);
        rst = 1'b0;
        @(negedge clk);

        // table walk, scan length 1
        for (int k = 0; k < NV; k++) begin
            cfg_gain = VECS[k].gain; cfg_bias = VECS[k].bias;
            cfg_bias_neg = VECS[k].neg; cfg_slope_inv = VECS[k].inv;
            cfg_live_zero = VECS[k].live; cfg_fmax = VECS[k].fmax;
            drive(1'b1, VECS[k].s0, 1'b0);
            drive(1'b1, VECS[k].s1, 1'b0);
            drive(1'b0, 12'd0, 1'b1);
            wait_out($sformatf("R1-R6 vector %0d", k), int'(VECS[k].expf));
        end

        // R10: empty window reuses average 819 with new settings
        set_plain(16'd6000);
        drive(1'b0, 12'd0, 1'b1);
        wait_out("R10 empty window", 1200);

        // R8: sample coinciding with the closing tick
        drive(1'b1, 12'd0, 1'b0);
        drive(1'b1, 12'd4095, 1'b1);
        wait_out("R8 same-cycle sample", 3001);
        drive(1'b0, 12'd0, 1'b1);
        wait_out("R8 cleared after close", 3001);

        // R9: limit changed right after boundary does not reach pending result
        drive(1'b1, 12'd2048, 1'b0);
        drive(1'b1, 12'd2048, 1'b1);
        cfg_fmax = 16'd3000;
        wait_out("R9 pending result", 3001);
        cfg_fmax = 16'd6000;

        // R7: three-tick window, scan shortened mid-window
        cfg_scan = 7'd3;
        drive(1'b0, 12'd0, 1'b1);
        wait_out("R7 flush", 3001);
        drive(1'b1, 12'd4095, 1'b0);
        drive(1'b0, 12'd0, 1'b1);
        cfg_scan = 7'd1;
        expect_quiet("R7 no result after tick 1", 60);
        drive(1'b1, 12'd0, 1'b0);
        drive(1'b0, 12'd0, 1'b1);
        expect_quiet("R9 window length kept after tick 2", 60);
        drive(1'b1, 12'd4095, 1'b0);
        drive(1'b0, 12'd0, 1'b1);
        wait_out("R7 three-tick average", 4000);

        // R12: reset mid-window with scan 3 latched
        cfg_scan = 7'd3;
        drive(1'b0, 12'd0, 1'b1);
        wait_out("R12 prep", 4000);
        drive(1'b1, 12'd4095, 1'b0);
        drive(1'b1, 12'd4095, 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(freq_out == 16'd0, "R12 freq cleared", int'(freq_out), 0);
        check(!freq_valid, "R12 strobe cleared", int'(freq_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        drive(1'b1, 12'd1000, 1'b0);
        drive(1'b0, 12'd0, 1'b1);
        wait_out("R12 accumulator and scan restarted", 1465);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule